// File: doc/BRIEF.md
# Configuration Session Sequencer

This block runs one complete configuration session on a programmable target, with no processor in the loop. When a session is requested, it first checks the request. It then turns the mode-select setting into a bus width and a clock-to-data ratio. Next it drives the target's control lines in a fixed order and follows the target through its phases: reset, configuration, configuration complete, initialization and user mode. Every phase has its own poll budget, and running out of it gives an error code that names that phase.

Between phases the sequencer asks an external clock generator for bursts of extra data clocks. It uses a request/acknowledge handshake, and the burst length goes out on a count bus. A short burst follows configuration complete and a long burst follows initialization. If the target already reports user mode while the sequencer waits for initialization, the session ends at once with success. An abort input stops a session at any point.

The sequencer does not move configuration data and does not handle bus bridges. It only grants the data path, through a single enable line.

Top module: `cfg_seq_top`

## Requirements
- R1: When the wide-mode bit is 1, rate codes 0, 1 and 2 latch `cd_ratio_o` = 0, 2 and 3, and `cfg_wide_o` = 1. The ratio encoding is 0 = x1, 1 = x2, 2 = x4, 3 = x8.
- R2: When the wide-mode bit is 0, rate codes 0, 1 and 2 latch `cd_ratio_o` = 0, 1 and 2 (x1, x2, x4), and `cfg_wide_o` = 0.
- R3: An accepted start drives `nce_o` low on the first clock edge. It raises `drv_en_o` on the next edge and raises `tgt_rst_pull_o` on the edge after that.
- R4: When `phase_i` = 1 (reset) is seen, the pull is released. When `phase_i` = 2 (configuring) is seen next, `irq_clr_o` is all ones for exactly one cycle and `dpath_en_o` rises.
- R5: Each wait samples its condition for at most POLL_LIMIT cycles and then ends the session with its own code. The codes are 3 (reset), 4 (configuring), 6 (config done), 7 (init) and 8 (user).
- R6: In the config-done wait, `tgt_stat_n_i` low ends the session with code 5, and this takes priority. Otherwise `tgt_cfg_done_i` high drops `dpath_en_o` and requests a burst of SHORT_BURST clocks.
- R7: `burst_req_o` stays high with `burst_cnt_o` stable until `burst_ack_i` is sampled. The next wait starts on the following cycle.
- R8: In the init wait, `phase_i` = 3 (init) requests a burst of LONG_BURST clocks. `phase_i` = 4 (user) ends the session at once with success and no long burst.
- R9: When user mode is seen in the final wait, the session ends with `done_o` = 1, `busy_o` = 0, `err_o` = 0, and all drives released (`nce_o` high, the rest low).
- R10: A start with `addr_lo_i` nonzero sets `err_o` = 1 and drives nothing.
- R11: A start with rate code 3 sets `err_o` = 2 and drives nothing. Alignment is checked first.
- R12: `abort_i` returns the sequencer to idle on the next edge. It releases all drives, clears `done_o` and `err_o`, and wins over `start_i`.
- R13: Once a session is running, `start_i` is ignored. `done_o` and `err_o` hold until the next start or abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Session request, sampled in idle |
| abort_i | input | 1 | Abandon the session and return to idle |
| addr_lo_i | input | 2 | Low two bits of the image address |
| mode_wide_i | input | 1 | 1 selects the 32-bit configuration width |
| mode_rate_i | input | 2 | Rate code for the clock-to-data ratio |
| phase_i | input | 3 | Target phase: 0 off, 1 reset, 2 configuring, 3 init, 4 user |
| tgt_stat_n_i | input | 1 | Target status, low on a configuration fault |
| tgt_cfg_done_i | input | 1 | Target reports configuration complete |
| burst_ack_i | input | 1 | Clock generator accepts the burst request |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | Last session succeeded |
| err_o | output | 4 | Error code of the last session, 0 for none |
| cfg_wide_o | output | 1 | Latched width selection |
| cd_ratio_o | output | 2 | Latched clock-to-data ratio code |
| nce_o | output | 1 | Target chip enable, active low |
| drv_en_o | output | 1 | Take control of the configuration lines |
| tgt_rst_pull_o | output | 1 | Hold the target in reset |
| dpath_en_o | output | 1 | Grant the configuration data path |
| irq_clr_o | output | 12 | Status-latch clear mask, one-cycle pulse |
| burst_req_o | output | 1 | Extra-clock burst request |
| burst_cnt_o | output | 16 | Length of the requested burst |

## Verification
The bench targets the edge of each poll budget. A counter that is off by one would give the timeout code one cycle early or late, and the per-clock comparison would show that. It drives a status fault and config-done together: a design with the wrong priority would report success where code 5 is due. It enters user mode during the init wait: a design without the early exit would raise a long burst request and hang in the user wait. It also sends a misaligned request with a bad rate, and a start in the middle of a session. A design with the wrong priority in either case would show the wrong code, or would drop a running session.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  localparam int ERR_W   = 4;
  localparam int PHASE_W = 3;

  typedef enum logic [ERR_W-1:0] {
    E_NONE     = 4'd0,
    E_ALIGN    = 4'd1,
    E_MODE     = 4'd2,
    E_RST_TO   = 4'd3,
    E_CFG_TO   = 4'd4,
    E_CFG_FAIL = 4'd5,
    E_CD_TO    = 4'd6,
    E_INIT_TO  = 4'd7,
    E_USER_TO  = 4'd8
  } err_e;

  typedef enum logic [PHASE_W-1:0] {
    PH_OFF    = 3'd0,
    PH_RESET  = 3'd1,
    PH_CONFIG = 3'd2,
    PH_INIT   = 3'd3,
    PH_USER   = 3'd4
  } phase_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CE,
    S_DRV,
    S_W_RST,
    S_W_CFG,
    S_W_CD,
    S_BURST_A,
    S_W_INIT,
    S_BURST_B,
    S_W_USER
  } state_e;

  typedef enum logic [1:0] {
    R_X1 = 2'd0,
    R_X2 = 2'd1,
    R_X4 = 2'd2,
    R_X8 = 2'd3
  } ratio_e;

endpackage

// File: rtl/cfg_mode_decode.sv
module cfg_mode_decode
  import cfg_seq_pkg::*;
(
  input  logic       wide_i,
  input  logic [1:0] rate_i,
  output logic [1:0] ratio_o,
  output logic       bad_o
);

  always_comb begin
    bad_o   = 1'b0;
    ratio_o = R_X1;
    case (rate_i)
      2'd0: ratio_o = R_X1;
      2'd1: ratio_o = wide_i ? R_X4 : R_X2;
      2'd2: ratio_o = wide_i ? R_X8 : R_X4;
      default: bad_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/cfg_poll_timer.sv
module cfg_poll_timer #(
  parameter int unsigned LIMIT = 32'h0100_0000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic clr_i,
  output logic expired_o
);

  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  // The clear cycle is poll 0, so the counter restarts at 1.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= CNT_W'(1);
    end else if (run_i && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = run_i && !clr_i && (cnt_q == LAST);

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int unsigned SHORT_BURST = 4,
  parameter int unsigned LONG_BURST  = 20480,
  parameter int          BCNT_W      = 16,
  parameter int          IRQ_W       = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [1:0]        addr_lo_i,
  input  logic              wide_i,
  input  logic [1:0]        ratio_i,
  input  logic              mode_bad_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic              stat_n_i,
  input  logic              cfg_done_i,
  input  logic              burst_ack_i,
  input  logic              tmo_i,
  output logic              tmr_run_o,
  output logic              tmr_clr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ERR_W-1:0]  err_o,
  output logic              cfg_wide_o,
  output logic [1:0]        cd_ratio_o,
  output logic              nce_o,
  output logic              drv_en_o,
  output logic              pull_o,
  output logic              dpath_en_o,
  output logic [IRQ_W-1:0]  irq_clr_o,
  output logic              burst_req_o,
  output logic [BCNT_W-1:0] burst_cnt_o
);

  state_e           state_q;
  logic             irq_q;
  logic             enter_q;
  logic             fail_c;
  logic             win_c;
  logic [ERR_W-1:0] fail_code_c;

  // Wait-state outcomes, decided before the register update.
  always_comb begin
    fail_c      = 1'b0;
    win_c       = 1'b0;
    fail_code_c = E_NONE;
    case (state_q)
      S_W_RST: if (phase_i != PH_RESET && tmo_i) begin
        fail_c = 1'b1; fail_code_c = E_RST_TO;
      end
      S_W_CFG: if (phase_i != PH_CONFIG && tmo_i) begin
        fail_c = 1'b1; fail_code_c = E_CFG_TO;
      end
      S_W_CD: begin
        if (!stat_n_i) begin
          fail_c = 1'b1; fail_code_c = E_CFG_FAIL;
        end else if (!cfg_done_i && tmo_i) begin
          fail_c = 1'b1; fail_code_c = E_CD_TO;
        end
      end
      S_W_INIT: begin
        if (phase_i == PH_USER) begin
          win_c = 1'b1;
        end else if (phase_i != PH_INIT && tmo_i) begin
          fail_c = 1'b1; fail_code_c = E_INIT_TO;
        end
      end
      S_W_USER: begin
        if (phase_i == PH_USER) begin
          win_c = 1'b1;
        end else if (tmo_i) begin
          fail_c = 1'b1; fail_code_c = E_USER_TO;
        end
      end
      default: ;
    endcase
  end

  assign tmr_run_o = (state_q == S_W_RST) || (state_q == S_W_CFG) || (state_q == S_W_CD) ||
                     (state_q == S_W_INIT) || (state_q == S_W_USER);
  assign tmr_clr_o = enter_q;
  assign irq_clr_o = {IRQ_W{irq_q}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= E_NONE;
      cfg_wide_o  <= 1'b0;
      cd_ratio_o  <= R_X1;
      nce_o       <= 1'b1;
      drv_en_o    <= 1'b0;
      pull_o      <= 1'b0;
      dpath_en_o  <= 1'b0;
      irq_q       <= 1'b0;
      burst_req_o <= 1'b0;
      burst_cnt_o <= '0;
      enter_q     <= 1'b0;
    end else begin
      irq_q   <= 1'b0;
      enter_q <= 1'b0;
      if (abort_i || fail_c || win_c) begin
        state_q     <= S_IDLE;
        busy_o      <= 1'b0;
        nce_o       <= 1'b1;
        drv_en_o    <= 1'b0;
        pull_o      <= 1'b0;
        dpath_en_o  <= 1'b0;
        burst_req_o <= 1'b0;
        done_o      <= !abort_i && win_c;
        err_o       <= abort_i ? E_NONE : fail_code_c;
      end else begin
        case (state_q)
          S_IDLE: if (start_i) begin
            done_o <= 1'b0;
            if (addr_lo_i != 2'b00) begin
              err_o <= E_ALIGN;
            end else if (mode_bad_i) begin
              err_o <= E_MODE;
            end else begin
              err_o      <= E_NONE;
              busy_o     <= 1'b1;
              cfg_wide_o <= wide_i;
              cd_ratio_o <= ratio_i;
              nce_o      <= 1'b0;
              state_q    <= S_CE;
            end
          end
          S_CE: begin
            drv_en_o <= 1'b1;
            state_q  <= S_DRV;
          end
          S_DRV: begin
            pull_o  <= 1'b1;
            enter_q <= 1'b1;
            state_q <= S_W_RST;
          end
          S_W_RST: if (phase_i == PH_RESET) begin
            pull_o  <= 1'b0;
            enter_q <= 1'b1;
            state_q <= S_W_CFG;
          end
          S_W_CFG: if (phase_i == PH_CONFIG) begin
            irq_q      <= 1'b1;
            dpath_en_o <= 1'b1;
            enter_q    <= 1'b1;
            state_q    <= S_W_CD;
          end
          S_W_CD: if (cfg_done_i) begin
            dpath_en_o  <= 1'b0;
            burst_req_o <= 1'b1;
            burst_cnt_o <= BCNT_W'(SHORT_BURST);
            state_q     <= S_BURST_A;
          end
          S_BURST_A: if (burst_ack_i) begin
            burst_req_o <= 1'b0;
            enter_q     <= 1'b1;
            state_q     <= S_W_INIT;
          end
          S_W_INIT: if (phase_i == PH_INIT) begin
            burst_req_o <= 1'b1;
            burst_cnt_o <= BCNT_W'(LONG_BURST);
            state_q     <= S_BURST_B;
          end
          S_BURST_B: if (burst_ack_i) begin
            burst_req_o <= 1'b0;
            enter_q     <= 1'b1;
            state_q     <= S_W_USER;
          end
          default: ;
        endcase
      end
    end
  end

  AST_PULL_UNDER_DRIVE: assert property (@(posedge clk) disable iff (rst)
    pull_o |-> (drv_en_o && !nce_o));  // R3
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (irq_clr_o != '0) |=> (irq_clr_o == '0));  // R4
  AST_DPATH_IN_SESSION: assert property (@(posedge clk) disable iff (rst)
    dpath_en_o |-> busy_o);  // R4
  AST_BURST_HELD: assert property (@(posedge clk) disable iff (rst)
    (burst_req_o && !burst_ack_i && !abort_i) |=> (burst_req_o && $stable(burst_cnt_o)));  // R7
  AST_DONE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (err_o == E_NONE && !busy_o));  // R9
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!busy_o && nce_o && !drv_en_o && !pull_o && !burst_req_o && err_o == E_NONE));  // R12

endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
  import cfg_seq_pkg::*;
#(
  parameter int unsigned POLL_LIMIT  = 32'h0100_0000,
  parameter int unsigned SHORT_BURST = 4,
  parameter int unsigned LONG_BURST  = 20480,
  parameter int          BCNT_W      = 16,
  parameter int          IRQ_W       = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [1:0]        addr_lo_i,
  input  logic              mode_wide_i,
  input  logic [1:0]        mode_rate_i,
  input  logic [2:0]        phase_i,
  input  logic              tgt_stat_n_i,
  input  logic              tgt_cfg_done_i,
  input  logic              burst_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [3:0]        err_o,
  output logic              cfg_wide_o,
  output logic [1:0]        cd_ratio_o,
  output logic              nce_o,
  output logic              drv_en_o,
  output logic              tgt_rst_pull_o,
  output logic              dpath_en_o,
  output logic [IRQ_W-1:0]  irq_clr_o,
  output logic              burst_req_o,
  output logic [BCNT_W-1:0] burst_cnt_o
);

  logic [1:0] ratio_w;
  logic       bad_w;
  logic       tmo_w;
  logic       run_w;
  logic       clr_w;

  cfg_mode_decode u_decode (
    .wide_i  (mode_wide_i),
    .rate_i  (mode_rate_i),
    .ratio_o (ratio_w),
    .bad_o   (bad_w)
  );

  cfg_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .run_i     (run_w),
    .clr_i     (clr_w),
    .expired_o (tmo_w)
  );

  cfg_seq_ctrl #(
    .SHORT_BURST (SHORT_BURST),
    .LONG_BURST  (LONG_BURST),
    .BCNT_W      (BCNT_W),
    .IRQ_W       (IRQ_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .abort_i     (abort_i),
    .addr_lo_i   (addr_lo_i),
    .wide_i      (mode_wide_i),
    .ratio_i     (ratio_w),
    .mode_bad_i  (bad_w),
    .phase_i     (phase_i),
    .stat_n_i    (tgt_stat_n_i),
    .cfg_done_i  (tgt_cfg_done_i),
    .burst_ack_i (burst_ack_i),
    .tmo_i       (tmo_w),
    .tmr_run_o   (run_w),
    .tmr_clr_o   (clr_w),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .cfg_wide_o  (cfg_wide_o),
    .cd_ratio_o  (cd_ratio_o),
    .nce_o       (nce_o),
    .drv_en_o    (drv_en_o),
    .pull_o      (tgt_rst_pull_o),
    .dpath_en_o  (dpath_en_o),
    .irq_clr_o   (irq_clr_o),
    .burst_req_o (burst_req_o),
    .burst_cnt_o (burst_cnt_o)
  );

endmodule

// File: tb/tb_cfg_seq_top.sv
module tb_cfg_seq_top;

  localparam int TMO   = 16;
  localparam int SHORT = 4;
  localparam int LONG  = 40;

  logic clk = 1'b0;
  logic rst, start_i, abort_i, mode_wide_i, tgt_stat_n_i, tgt_cfg_done_i, burst_ack_i;
  logic [1:0] addr_lo_i, mode_rate_i;
  logic [2:0] phase_i;
  logic busy_o, done_o, cfg_wide_o, nce_o, drv_en_o, tgt_rst_pull_o, dpath_en_o, burst_req_o;
  logic [3:0] err_o;
  logic [1:0] cd_ratio_o;
  logic [11:0] irq_clr_o;
  logic [15:0] burst_cnt_o;

  always #2 clk = ~clk;

  cfg_seq_top #(.POLL_LIMIT(TMO), .SHORT_BURST(SHORT), .LONG_BURST(LONG)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i), .addr_lo_i(addr_lo_i),
    .mode_wide_i(mode_wide_i), .mode_rate_i(mode_rate_i), .phase_i(phase_i),
    .tgt_stat_n_i(tgt_stat_n_i), .tgt_cfg_done_i(tgt_cfg_done_i), .burst_ack_i(burst_ack_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .cfg_wide_o(cfg_wide_o),
    .cd_ratio_o(cd_ratio_o), .nce_o(nce_o), .drv_en_o(drv_en_o), .tgt_rst_pull_o(tgt_rst_pull_o),
    .dpath_en_o(dpath_en_o), .irq_clr_o(irq_clr_o), .burst_req_o(burst_req_o),
    .burst_cnt_o(burst_cnt_o)
  );

  int tests = 0;
  int fails = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_ratio(input bit w, input int r);
    if (w) return (r == 0) ? 0 : (r == 1) ? 2 : 3;  // R1 x1,x4,x8
    return r;                                       // R2 x1,x2,x4
  endfunction

  // Behavioural reference: step = where in the session, polls = samples so far.
  int m_step, m_polls, m_err, m_ratio, m_bcnt;
  bit m_busy, m_done, m_wide, m_nce, m_drv, m_pull, m_dp, m_irq, m_breq;

  task automatic m_end(input int code, input bit ok);
    m_step = 0; m_busy = 0; m_nce = 1; m_drv = 0; m_pull = 0; m_dp = 0; m_breq = 0;
    m_err = code; m_done = ok;
  endtask

  task automatic m_tick(input int code);
    if (m_polls == TMO - 1) m_end(code, 0);
    else m_polls++;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_step = 0; m_polls = 0; m_err = 0; m_ratio = 0; m_bcnt = 0;
      m_busy = 0; m_done = 0; m_wide = 0; m_nce = 1; m_drv = 0; m_pull = 0;
      m_dp = 0; m_irq = 0; m_breq = 0;
    end else begin
      m_irq = 0;
      if (abort_i) m_end(0, 0);
      else case (m_step)
        0: if (start_i) begin
          m_done = 0;
          if (addr_lo_i != 0) m_err = 1;
          else if (mode_rate_i == 3) m_err = 2;
          else begin
            m_err = 0; m_busy = 1; m_wide = mode_wide_i;
            m_ratio = exp_ratio(mode_wide_i, int'(mode_rate_i)); m_nce = 0; m_step = 1;
          end
        end
        1: begin m_drv = 1; m_step = 2; end
        2: begin m_pull = 1; m_step = 3; m_polls = 0; end
        3: if (phase_i == 1) begin m_pull = 0; m_step = 4; m_polls = 0; end else m_tick(3);
        4: if (phase_i == 2) begin m_irq = 1; m_dp = 1; m_step = 5; m_polls = 0; end else m_tick(4);
        5: if (!tgt_stat_n_i) m_end(5, 0);
           else if (tgt_cfg_done_i) begin m_dp = 0; m_breq = 1; m_bcnt = SHORT; m_step = 6; end
           else m_tick(6);
        6: if (burst_ack_i) begin m_breq = 0; m_step = 7; m_polls = 0; end
        7: if (phase_i == 4) m_end(0, 1);
           else if (phase_i == 3) begin m_breq = 1; m_bcnt = LONG; m_step = 8; end
           else m_tick(7);
        8: if (burst_ack_i) begin m_breq = 0; m_step = 9; m_polls = 0; end
        9: if (phase_i == 4) m_end(0, 1); else m_tick(8);
        default: ;
      endcase
    end
  end

  // Per-clock comparison against the reference.
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1 cfg_wide_o", cfg_wide_o, m_wide);
      chk("R2 cd_ratio_o", cd_ratio_o, m_ratio);
      chk("R3 nce_o", nce_o, m_nce);
      chk("R3 drv_en_o", drv_en_o, m_drv);
      chk("R4 tgt_rst_pull_o", tgt_rst_pull_o, m_pull);
      chk("R4 dpath_en_o", dpath_en_o, m_dp);
      chk("R4 irq_clr_o", irq_clr_o, m_irq ? 12'hFFF : 0);
      chk("R7 burst_req_o", burst_req_o, m_breq);
      chk("R7 burst_cnt_o", burst_cnt_o, m_bcnt);
      chk("R9 busy_o", busy_o, m_busy);
      chk("R9 done_o", done_o, m_done);
      chk("R5 err_o", err_o, m_err);
    end
  end

  int wd = 0;
  always @(negedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++; tests++;
      $display("FAIL R9 watchdog actual=%0d expected=<150000", wd);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start(input bit w, input logic [1:0] r, input logic [1:0] a);
    mode_wide_i = w; mode_rate_i = r; addr_lo_i = a; start_i = 1;
    cyc(1);
    start_i = 0; addr_lo_i = 0;
  endtask

  task automatic quiet();
    phase_i = 0; tgt_stat_n_i = 1; tgt_cfg_done_i = 0; burst_ack_i = 0; abort_i = 0;
    cyc(3);
  endtask

  task automatic give_ack(input int expcnt, input string tag);
    for (int i = 0; i < 50 && !burst_req_o; i++) cyc(1);
    cyc(2);
    chk(tag, burst_cnt_o, expcnt);
    burst_ack_i = 1;
    cyc(1);
    burst_ack_i = 0;
  endtask

  // stop: 0 full run, else the error code the session is steered into.
  task automatic session(input bit w, input logic [1:0] r, input int stop, input bit early);
    pulse_start(w, r, 0);
    for (int i = 0; i < 20 && !tgt_rst_pull_o; i++) cyc(1);
    if (stop == 3) begin cyc(TMO + 4); quiet(); return; end
    cyc(2);
    phase_i = 1;
    for (int i = 0; i < 20 && tgt_rst_pull_o; i++) cyc(1);
    cyc(1);
    if (stop == 4) begin cyc(TMO + 4); quiet(); return; end
    phase_i = 2;
    for (int i = 0; i < 20 && !dpath_en_o; i++) cyc(1);
    cyc(2);
    if (stop == 5) begin tgt_stat_n_i = 0; tgt_cfg_done_i = 1; cyc(3); quiet(); return; end
    if (stop == 6) begin cyc(TMO + 4); quiet(); return; end
    tgt_cfg_done_i = 1;
    give_ack(SHORT, "R6 short burst length");
    cyc(2);
    if (stop == 7) begin cyc(TMO + 4); quiet(); return; end
    if (early) begin
      phase_i = 4;
      cyc(1);
      chk("R8 early user no long burst", burst_req_o, 0);
      cyc(2); quiet(); return;
    end
    phase_i = 3;
    give_ack(LONG, "R8 long burst length");
    cyc(2);
    if (stop == 8) begin cyc(TMO + 4); quiet(); return; end
    phase_i = 4;
    cyc(3);
    quiet();
  endtask

  initial begin
    rst = 1; start_i = 0; abort_i = 0; addr_lo_i = 0; mode_wide_i = 0; mode_rate_i = 0;
    phase_i = 0; tgt_stat_n_i = 1; tgt_cfg_done_i = 0; burst_ack_i = 0;
    cyc(3);
    rst = 0; cmp_on = 1;
    cyc(1);
    chk("R9 reset busy", busy_o, 0);
    chk("R3 reset nce high", nce_o, 1);
    chk("R5 reset err", err_o, 0);

    // R1/R2: ratio decode for every valid setting
    for (int w = 0; w < 2; w++)
      for (int r = 0; r < 3; r++) begin
        pulse_start(w[0], r[1:0], 0);
        chk(w ? "R1 ratio wide" : "R2 ratio narrow", cd_ratio_o, exp_ratio(w[0], r));
        chk(w ? "R1 width wide" : "R2 width narrow", cfg_wide_o, w);
        chk("R3 nce first", nce_o, 0);
        chk("R3 drv not yet", drv_en_o, 0);
        abort_i = 1; cyc(1); abort_i = 0;
        chk("R12 abort idle", busy_o, 0);
        cyc(1);
      end

    session(0, 2'd1, 0, 0);
    chk("R9 full success done", done_o, 1);
    chk("R9 full success err", err_o, 0);
    cyc(10);
    chk("R13 done holds", done_o, 1);

    session(1, 2'd2, 0, 1);
    chk("R8 early exit done", done_o, 1);

    session(1, 2'd1, 3, 0); chk("R5 reset timeout", err_o, 3);
    session(0, 2'd0, 4, 0); chk("R5 config timeout", err_o, 4);
    session(0, 2'd2, 5, 0); chk("R6 status fault beats done", err_o, 5);
    session(1, 2'd0, 6, 0); chk("R5 cfg done timeout", err_o, 6);
    session(0, 2'd1, 7, 0); chk("R5 init timeout", err_o, 7);
    session(1, 2'd2, 8, 0); chk("R5 user timeout", err_o, 8);

    pulse_start(0, 2'd0, 2'd2);
    chk("R10 misaligned", err_o, 1);
    chk("R10 no drive", nce_o, 1);
    pulse_start(1, 2'd3, 2'd0);
    chk("R11 bad rate", err_o, 2);
    chk("R11 no drive", drv_en_o, 0);
    pulse_start(1, 2'd3, 2'd1);
    chk("R11 alignment checked first", err_o, 1);

    // R13: start mid-session ignored; R12: abort wins over start
    pulse_start(0, 2'd0, 0);
    cyc(3);
    pulse_start(1, 2'd3, 2'd1);
    chk("R13 busy kept", busy_o, 1);
    chk("R13 err unchanged", err_o, 0);
    start_i = 1; abort_i = 1; cyc(1); start_i = 0; abort_i = 0;
    chk("R12 abort released pull", tgt_rst_pull_o, 0);
    chk("R12 abort beats start", busy_o, 0);
    cyc(2);
    chk("R12 stays idle", busy_o, 0);

    cmp_on = 0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule